// File: doc/BRIEF.md
# Clock Synthesizer Serial Loader

This block loads one 24-bit control word into an external programmable clock synthesizer over a two-wire serial link made of a clock line and a data line. A single start pulse begins a transaction. The block then produces the whole waveform by itself. First comes an unlock preamble, then a start bit. Next come the word bits, least significant first, each encoded as a four-step pattern that shows the complement of the bit before its true value. A stop bit ends the serial part.

Once the serial part is finished, the block looks at the three-bit register code in the top bits of the word. For the three video clock registers it drives the two clock-select outputs to the code. For any other register it puts back the select value that was present at the moment of the start pulse. The synthesizer output needs time to settle after the link goes quiet, so the done pulse waits for a settle counter to expire.

A step-length input sets how many system cycles each waveform step lasts. Codes 5 and 7 name no register and raise an error flag, but the word is still shifted out.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset and whenever the block is idle, the link clock and link data are low and busy, done and the error flag are low. After reset the select outputs are 0.
- R2: Every waveform step lasts L system cycles, where L is the value of step_div captured at the accepted start, with 0 treated as 1. Busy is high from the cycle after the accepted start until the done cycle.
- R3: The transaction opens with UNLOCK_N (default 5) pairs of steps. In each pair, data is high while the link clock is first low and then high.
- R4: After the preamble come four steps forming the start bit, given as (clock,data): (0,0), (1,0), (0,0), (1,0).
- R5: Bits 0 to 23 of the word follow in ascending order. Each bit b takes four steps, given as (clock,data): (1,~b), (0,~b), (0,b), (1,b).
- R6: The stop bit follows as three steps, given as (clock,data): (1,1), (0,1), (1,1). After it, the link returns to (0,0).
- R7: The error flag is high from the cycle after an accepted start when word bits [23:21] equal 5 or 7. It is low for other codes. It holds its value until the next accepted start.
- R8: When word bits [23:21] hold 0, 1 or 2, the select outputs take the low two bits of that code in the cycle after the stop bit ends.
- R9: For codes 3, 4, 5, 6 and 7, the select outputs take, in the cycle after the stop bit ends, the sel_in value captured at the accepted start.
- R10: Done is high for exactly one cycle, SETTLE_CYC cycles after the stop bit ends, and busy is low in that cycle.
- R11: A start pulse that arrives while busy is high has no effect. The waveform, the word, the select result and the timing of the running transaction are unchanged, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to load a word |
| ctrl_word | input | 24 | Control word; bits [23:21] select the target register |
| sel_in | input | 2 | Current clock-select state, captured at start |
| step_div | input | 8 | System cycles per waveform step (0 acts as 1) |
| syn_clk | output | 1 | Serial link clock |
| syn_data | output | 1 | Serial link data |
| sel_out | output | 2 | Clock-select outputs |
| busy | output | 1 | Transaction in progress |
| bad_reg | output | 1 | Register code is 5 or 7 |
| done | output | 1 | One-cycle completion pulse after settling |

## Verification
When start is accepted on clock edge E, waveform step k is visible from edge E+k*L to edge E+(k+1)*L. The last of the 113 steps ends at edge E+113*L. At that edge the select outputs change, and done follows at edge E+113*L+SETTLE_CYC. The bench drives inputs and samples outputs on falling edges. It numbers each sample by the rising edges since E, and from that number it computes the step expected in that cycle. This makes every pin comparison land in the exact cycle each result is due. The error flag is checked one cycle after start and again at done. A start pulse injected while a transaction is running is followed by a check that the waveform still matches the original word and that busy stays low after done.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;

  // Register codes that address no register in the synthesizer.
  function automatic logic code_is_bad(input logic [2:0] code);
    return (code == 3'd5) || (code == 3'd7);
  endfunction

  // Codes naming one of the three video clock registers.
  function automatic logic code_is_vclk(input logic [2:0] code);
    return code <= 3'd2;
  endfunction

  // Clamp a step length so that zero still gives one cycle per step.
  function automatic logic [7:0] step_len(input logic [7:0] div);
    return (div == 8'd0) ? 8'd1 : div;
  endfunction

endpackage

// File: rtl/synth_step_pacer.sv
module synth_step_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == len - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/synth_settle_timer.sv
module synth_settle_timer #(
  parameter int SETTLE_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!expire) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/synth_wave_shaper.sv
module synth_wave_shaper #(
  parameter int WORD_W   = 24,
  parameter int UNLOCK_N = 5,
  parameter int IDX_W    = 7
) (
  input  logic              active,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic              clk_o,
  output logic              data_o
);
  localparam int UNL_END = 2 * UNLOCK_N;
  localparam int STA_END = UNL_END + 4;
  localparam int BIT_END = STA_END + 4 * WORD_W;
  localparam int BSEL_W  = $clog2(WORD_W);

  logic [IDX_W-1:0]  off;
  logic [BSEL_W-1:0] bsel;
  logic              bitv;

  always_comb begin
    clk_o  = 1'b0;
    data_o = 1'b0;
    off    = '0;
    bsel   = '0;
    bitv   = 1'b0;
    if (active) begin
      if (int'(idx) < UNL_END) begin
        // preamble: data high, clock alternates low/high
        clk_o  = idx[0];
        data_o = 1'b1;
      end else if (int'(idx) < STA_END) begin
        off    = idx - IDX_W'(UNL_END);
        clk_o  = off[0];
        data_o = 1'b0;
      end else if (int'(idx) < BIT_END) begin
        off  = idx - IDX_W'(STA_END);
        bsel = off[2 +: BSEL_W];
        bitv = word[bsel];
        case (off[1:0])
          2'd0:    begin clk_o = 1'b1; data_o = ~bitv; end
          2'd1:    begin clk_o = 1'b0; data_o = ~bitv; end
          2'd2:    begin clk_o = 1'b0; data_o = bitv;  end
          default: begin clk_o = 1'b1; data_o = bitv;  end
        endcase
      end else begin
        off    = idx - IDX_W'(BIT_END);
        clk_o  = (off[1:0] != 2'd1);
        data_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int UNLOCK_N   = 5,
  parameter int DIV_W      = 8,
  parameter int SETTLE_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [1:0]        sel_in,
  input  logic [DIV_W-1:0]  step_div,
  output logic              syn_clk,
  output logic              syn_data,
  output logic [1:0]        sel_out,
  output logic              busy,
  output logic              bad_reg,
  output logic              done
);
  localparam int TOTAL = 2 * UNLOCK_N + 4 + 4 * WORD_W + 3;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  seq_state_t        state;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        sel_save;
  logic [DIV_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        code_q;

  // Named internal events, observed by the bound checker.
  logic start_acc;
  logic step_tick;
  logic last_step;
  logic settle_hit;

  assign start_acc = start && (state == ST_IDLE);
  assign last_step = step_tick && (idx_q == LAST_IDX);
  assign code_q    = word_q[WORD_W-1 -: 3];

  synth_step_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_SEND),
    .len  (len_q),
    .tick (step_tick)
  );

  synth_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SETTLE),
    .expire(settle_hit)
  );

  synth_wave_shaper #(
    .WORD_W  (WORD_W),
    .UNLOCK_N(UNLOCK_N),
    .IDX_W   (IDX_W)
  ) u_shaper (
    .active(state == ST_SEND),
    .idx   (idx_q),
    .word  (word_q),
    .clk_o (syn_clk),
    .data_o(syn_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_q   <= '0;
      sel_save <= '0;
      len_q    <= DIV_W'(1);
      idx_q    <= '0;
      bad_reg  <= 1'b0;
      sel_out  <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_acc) begin
            state    <= ST_SEND;
            word_q   <= ctrl_word;
            sel_save <= sel_in;
            len_q    <= (step_div == '0) ? DIV_W'(1) : step_div;
            idx_q    <= '0;
            bad_reg  <= code_is_bad(ctrl_word[WORD_W-1 -: 3]);
          end
        end
        ST_SEND: begin
          if (last_step) begin
            state   <= ST_SETTLE;
            sel_out <= code_is_vclk(code_q) ? code_q[1:0] : sel_save;
          end else if (step_tick) begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_SETTLE: begin
          if (settle_hit) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_SEND) || (state == ST_SETTLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/synth_prog_seq_chk.sv
module synth_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       syn_clk,
  input logic       syn_data,
  input logic [1:0] sel_out,
  input logic       busy,
  input logic       bad_reg,
  input logic       done,
  input logic       start_acc,
  input logic       step_tick,
  input logic       last_step,
  input logic       settle_hit
);
  // R1: link rests low whenever not busy
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!syn_clk && !syn_data));

  // R2: link clock moves only where a step boundary was reached
  assert_clk_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(syn_clk) |-> $past(step_tick));

  // R7: error flag can only rise right after an accepted start
  assert_bad_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_reg) |-> $past(start_acc));

  // R8 / R9: select outputs change only when the stop bit ends
  assert_sel_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_out) |-> $past(last_step));

  // R10: done follows settle expiry, lasts one cycle, busy low
  assert_done_after_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(settle_hit));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11: no start is accepted while a transaction runs
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_acc);
endmodule

bind synth_prog_seq synth_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .syn_clk   (syn_clk),
  .syn_data  (syn_data),
  .sel_out   (sel_out),
  .busy      (busy),
  .bad_reg   (bad_reg),
  .done      (done),
  .start_acc (start_acc),
  .step_tick (step_tick),
  .last_step (last_step),
  .settle_hit(settle_hit)
);

// File: tb/synth_prog_seq_test.sv
`timescale 1ns/1ps
module synth_prog_seq_test;
  localparam int SETTLE = 40;
  localparam int NSTEP  = 113;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ctrl_word = '0;
  logic [1:0]  sel_in = '0;
  logic [7:0]  step_div = 8'd1;
  logic        syn_clk, syn_data, busy, bad_reg, done;
  logic [1:0]  sel_out;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  synth_prog_seq #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .sel_in(sel_in), .step_div(step_div), .syn_clk(syn_clk),
    .syn_data(syn_data), .sel_out(sel_out), .busy(busy),
    .bad_reg(bad_reg), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected {clock,data} in waveform step k, worked out from R3..R6.
  function automatic logic [1:0] want_pins(int k, logic [23:0] w);
    int p;
    logic b;
    if (k < 10) return {1'(k % 2), 1'b1};
    if (k < 14) return {1'((k - 10) % 2), 1'b0};
    if (k < 110) begin
      b = w[(k - 14) / 4];
      p = (k - 14) % 4;
      if (p == 0) return {1'b1, ~b};
      if (p == 1) return {1'b0, ~b};
      if (p == 2) return {1'b0, b};
      return {1'b1, b};
    end
    return {1'(k != 111), 1'b1};
  endfunction

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pins", {syn_clk, syn_data}, 0);
    check("R1 reset busy/done/bad", {busy, done, bad_reg}, 0);
    check("R1 reset sel", sel_out, 0);
  endtask

  // One full transaction; inject > 0 pulses start at that sample index.
  task automatic run_txn(input logic [23:0] w, input logic [1:0] si,
                         input logic [7:0] div, input int inject);
    int L, send, m3, m4, m5, m6, busy_bad, done_at, done_cnt;
    logic [2:0] code;
    logic [1:0] exp_sel;
    L = (div == 0) ? 1 : int'(div);
    send = NSTEP * L;
    code = w[23:21];
    exp_sel = (code <= 3'd2) ? code[1:0] : si;
    m3 = 0; m4 = 0; m5 = 0; m6 = 0; busy_bad = 0; done_at = -1; done_cnt = 0;
    @(negedge clk);
    ctrl_word = w; sel_in = si; step_div = div; start = 1'b1;
    for (int m = 1; m <= send + SETTLE + 6; m++) begin
      @(negedge clk);
      if (m == 1) begin
        start = 1'b0;
        ctrl_word = ~w; sel_in = ~si; step_div = div + 8'd2;
        check("R7 flag after start", bad_reg, int'(code == 5 || code == 7));
      end
      if (inject > 0 && m == inject) begin
        start = 1'b1; ctrl_word = 24'h5A5A5A;
      end
      if (inject > 0 && m == inject + 1) start = 1'b0;
      if (m <= send) begin
        int k = (m - 1) / L;
        if ({syn_clk, syn_data} != want_pins(k, w)) begin
          if (k < 10) m3++; else if (k < 14) m4++;
          else if (k < 110) m5++; else m6++;
        end
      end else if ({syn_clk, syn_data} != 2'b00) m6++;
      if (m <= send + SETTLE && !busy) busy_bad++;
      if (m == send + 1) check("R8/R9 select result", sel_out, exp_sel);
      if (done) begin done_cnt++; if (done_at < 0) done_at = m; end
    end
    check("R3 unlock mismatches", m3, 0);
    check("R4 start-bit mismatches", m4, 0);
    check("R5 data-bit mismatches", m5, 0);
    check("R6 stop/idle mismatches", m6, 0);
    check("R2 busy gaps", busy_bad, 0);
    check("R10 done cycle", done_at, send + SETTLE + 1);
    check("R10 done pulse count", done_cnt, 1);
    check("R7 flag held", bad_reg, int'(code == 5 || code == 7));
    check("R1 idle after done", {busy, syn_clk, syn_data}, 0);
    if (code <= 3'd2) check("R8 final select", sel_out, code[1:0]);
    else              check("R9 final select", sel_out, si);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    reset_check();
    run_txn({3'd1, 21'h0A5C3}, 2'd3, 8'd1, 0);   // R8, vclk code 1
    run_txn({3'd6, 21'h13579}, 2'd2, 8'd3, 0);   // R9, control register
    run_txn({3'd5, 21'h1FFFF}, 2'd1, 8'd2, 0);   // R7 illegal, R9 restore
    run_txn({3'd7, 21'h00000}, 2'd2, 8'd1, 0);   // R7 illegal code 7
    run_txn({3'd0, 21'h1C0DE}, 2'd3, 8'd0, 0);   // R2 zero acts as one
    run_txn({3'd2, 21'h0F0F0}, 2'd1, 8'd2, 30);  // R11 start while busy
    repeat (5) @(negedge clk);
    check("R11 no second transaction", {busy, done}, 0);
    run_txn({3'd3, 21'h12345}, 2'd0, 8'd1, 0);   // R9 memory clock code
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule